// File: doc/BRIEF.md
# Serial Byte DMA Word Packer

This block moves single characters between word-aligned memory and one serial channel. It reaches memory through a simple request interface. Each request carries an address, a write flag and write data. The request stays up until the memory answers with ready. A start pulse hands the block a base address and a direction.

When sending, the block reads one 32-bit word at a time. It passes the byte in lane 1 to the serial transmitter and steps the address by four. It stops once the stepped address reaches a 4 KB page boundary. When receiving, the block takes one byte at a time from the receive queue and writes it to memory as a full word, with the byte copied into all four lanes. It stops when the queue has nothing pending or when the stepped address reaches a 2 KB half-page boundary, whichever comes first.

Every transfer ends with a one-cycle done pulse. The final byte count, equal to four per word moved, is published with that pulse. When loopback is enabled, each transmitted byte is also sent out on a loopback output, so the surrounding logic can feed it back into its receive queue.

Top module: `byte_dma_packer`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o, tx_valid_o and lb_valid_o are 0, and count_o is 0.
- R2: With dir_i = 0 (send), each word read from memory yields one byte on tx_data_o, taken from bits 15:8 of mem_rdata_i. Bits 31:16 and 7:0 have no effect. tx_valid_o and tx_data_o hold until tx_ready_i accepts the byte.
- R3: A send reads consecutive words starting at the aligned base, stepping by 4. The next word is read only after the previous byte has been accepted. The send ends after the word whose stepped address has bits 11:2 all zero.
- R4: With dir_i = 1 (receive), each byte accepted while rx_valid_i and rx_ready_o are both high is written (mem_we_o = 1) at consecutive word addresses from the aligned base. The write data holds that byte in all four byte lanes.
- R5: A receive ends when no byte is pending at the moment the next one is wanted. It also ends after the write whose stepped address has bits 10:2 all zero. Any bytes still queued after that stay unaccepted.
- R6: At the end of each transfer, done_o is high for exactly one cycle. count_o then shows 4 times the number of words moved, and it holds that value until the next done pulse.
- R7: When loop_en_i is 1, each byte accepted by the transmitter appears once on lb_data_o, with lb_valid_o high for one cycle. When loop_en_i is 0, lb_valid_o stays low.
- R8: At most one memory request is outstanding at any time. While mem_rdy_i is low, the request holds its address, write flag and data stable. A send issues only reads.
- R9: A start_i pulse that arrives while busy_o is high is ignored.
- R10: Bits 1:0 of base_i are ignored. Every request address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| dir_i | input | 1 | 0 send from memory, 1 receive into memory |
| base_i | input | AW | Start byte address |
| loop_en_i | input | 1 | Enable loopback of transmitted bytes |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | Request word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with mem_rdy_i |
| mem_rdy_i | input | 1 | Memory completes the current request |
| tx_valid_o | output | 1 | Byte offered to transmitter |
| tx_data_o | output | 8 | Byte to transmit |
| tx_ready_i | input | 1 | Transmitter accepts the byte |
| rx_valid_i | input | 1 | Receive queue holds a byte |
| rx_data_i | input | 8 | Head byte of the receive queue |
| rx_ready_o | output | 1 | Block takes the head byte |
| lb_valid_o | output | 1 | Loopback byte valid, one cycle |
| lb_data_o | output | 8 | Loopback byte |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| count_o | output | CW | Bytes moved by the last transfer |

## Verification
The assertions assume the following about the environment. mem_rdy_i is seen only while a request is up, and read data is valid in the cycle that ready arrives. The receive queue keeps its head byte and valid flag steady until the byte is taken. The transmitter may stall for any number of cycles.

The bench drives every input on the falling clock edge and keeps the queue head fixed until the handshake edge has passed. The memory model always answers reads with data computed from the address. Ready and transmitter-accept gaps follow fixed cycle patterns, so the stalls land at varied points within each transfer.

// File: rtl/dpk_pkg.sv
package dpk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TXRD   = 3'd1,
    ST_TXOUT  = 3'd2,
    ST_RXPOLL = 3'd3,
    ST_RXWR   = 3'd4
  } dpk_state_e;
endpackage

// File: rtl/dpk_addr_walk.sv
// Word address register with boundary detection on the stepped address.
module dpk_addr_walk #(
  parameter int AW           = 32,
  parameter int STEP         = 4,
  parameter int TX_SPAN_BITS = 12,
  parameter int RX_SPAN_BITS = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base_i,
  input  logic          step,
  input  logic          rx_mode,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] addr_nx,
  output logic          at_end
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(STEP - 1);
  localparam logic [AW-1:0] TX_MASK = AW'((64'd1 << TX_SPAN_BITS) - 64'd1) & ALIGN_MASK;
  localparam logic [AW-1:0] RX_MASK = AW'((64'd1 << RX_SPAN_BITS) - 64'd1) & ALIGN_MASK;

  assign addr_nx = addr_q + AW'(STEP);
  assign at_end  = ((addr_nx & (rx_mode ? RX_MASK : TX_MASK)) == '0);

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= base_i & ALIGN_MASK;
    else if (step) addr_q <= addr_nx;
  end
endmodule

// File: rtl/dpk_lanes.sv
// Byte lane extraction for sending, lane replication for receiving.
module dpk_lanes #(
  parameter int DW       = 32,
  parameter int LANE_SEL = 1
) (
  input  logic [DW-1:0] word_i,
  output logic [7:0]    pick_o,
  input  logic [7:0]    byte_i,
  output logic [DW-1:0] rep_o
);
  localparam int NL = DW / 8;

  always_comb begin
    pick_o = '0;
    for (int i = 0; i < NL; i++) begin
      if (i == LANE_SEL) pick_o = pick_o | word_i[i*8 +: 8];
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_rep
    assign rep_o[g*8 +: 8] = byte_i;
  end
endmodule

// File: rtl/dpk_mem_port.sv
// Single outstanding memory request, held until ready.
module dpk_mem_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rdy_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          ack_o
);
  assign ack_o = req_o & rdy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (issue) begin
      req_o   <= 1'b1;
      we_o    <= we_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end else if (ack_o) begin
      req_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_dma_packer.sv
module byte_dma_packer
  import dpk_pkg::*;
#(
  parameter int AW           = 32,
  parameter int DW           = 32,
  parameter int LANE_SEL     = 1,
  parameter int TX_SPAN_BITS = 12,
  parameter int RX_SPAN_BITS = 11,
  parameter int CW           = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          dir_i,
  input  logic [AW-1:0] base_i,
  input  logic          loop_en_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rdy_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ready_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  output logic          rx_ready_o,
  output logic          lb_valid_o,
  output logic [7:0]    lb_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] count_o
);
  localparam int BYTES = DW / 8;
  localparam logic [CW-1:0] CNT_STEP = CW'(BYTES);

  dpk_state_e    state_q;
  logic          rx_mode_q;
  logic [CW-1:0] cnt_q;

  logic          walk_load, walk_step, at_end;
  logic [AW-1:0] addr_q, addr_nx;
  logic          issue, issue_we, ack;
  logic [AW-1:0] issue_addr;
  logic [7:0]    pick;
  logic [DW-1:0] rep;

  dpk_addr_walk #(
    .AW(AW), .STEP(BYTES), .TX_SPAN_BITS(TX_SPAN_BITS), .RX_SPAN_BITS(RX_SPAN_BITS)
  ) u_walk (
    .clk(clk), .rst(rst), .load(walk_load), .base_i(base_i), .step(walk_step),
    .rx_mode(rx_mode_q), .addr_q(addr_q), .addr_nx(addr_nx), .at_end(at_end)
  );

  dpk_lanes #(.DW(DW), .LANE_SEL(LANE_SEL)) u_lanes (
    .word_i(mem_rdata_i), .pick_o(pick), .byte_i(rx_data_i), .rep_o(rep)
  );

  dpk_mem_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .issue(issue), .we_i(issue_we), .addr_i(issue_addr),
    .wdata_i(rep), .rdy_i(mem_rdy_i), .req_o(mem_req_o), .we_o(mem_we_o),
    .addr_o(mem_addr_o), .wdata_o(mem_wdata_o), .ack_o(ack)
  );

  assign rx_ready_o = (state_q == ST_RXPOLL);
  assign busy_o     = (state_q != ST_IDLE);

  // Request and address-walk control
  always_comb begin
    walk_load  = 1'b0;
    walk_step  = 1'b0;
    issue      = 1'b0;
    issue_we   = 1'b0;
    issue_addr = addr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          walk_load  = 1'b1;
          issue      = ~dir_i;
          issue_addr = base_i & ~AW'(BYTES - 1);
        end
      end
      ST_TXOUT: begin
        if (tx_valid_o && tx_ready_i) begin
          walk_step  = 1'b1;
          issue      = ~at_end;
          issue_addr = addr_nx;
        end
      end
      ST_RXPOLL: begin
        if (rx_valid_i) begin
          issue    = 1'b1;
          issue_we = 1'b1;
        end
      end
      ST_RXWR: walk_step = ack;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      rx_mode_q  <= 1'b0;
      cnt_q      <= '0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      lb_valid_o <= 1'b0;
      lb_data_o  <= '0;
      done_o     <= 1'b0;
      count_o    <= '0;
    end else begin
      done_o     <= 1'b0;
      lb_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cnt_q     <= '0;
            rx_mode_q <= dir_i;
            state_q   <= dir_i ? ST_RXPOLL : ST_TXRD;
          end
        end
        ST_TXRD: begin
          if (ack) begin
            tx_data_o  <= pick;
            tx_valid_o <= 1'b1;
            state_q    <= ST_TXOUT;
          end
        end
        ST_TXOUT: begin
          if (tx_valid_o && tx_ready_i) begin
            tx_valid_o <= 1'b0;
            lb_valid_o <= loop_en_i;
            lb_data_o  <= tx_data_o;
            cnt_q      <= cnt_q + CNT_STEP;
            if (at_end) begin
              done_o  <= 1'b1;
              count_o <= cnt_q + CNT_STEP;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_TXRD;
            end
          end
        end
        ST_RXPOLL: begin
          if (rx_valid_i) begin
            state_q <= ST_RXWR;
          end else begin
            done_o  <= 1'b1;
            count_o <= cnt_q;
            state_q <= ST_IDLE;
          end
        end
        ST_RXWR: begin
          if (ack) begin
            cnt_q <= cnt_q + CNT_STEP;
            if (at_end) begin
              done_o  <= 1'b1;
              count_o <= cnt_q + CNT_STEP;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_RXPOLL;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dpk_checker.sv
module dpk_checker #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_rdy_i,
  input logic          tx_valid_o,
  input logic [7:0]    tx_data_o,
  input logic          tx_ready_i,
  input logic          lb_valid_o,
  input logic          loop_en_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] count_o
);
  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> !mem_req_o);

  a_r10_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  a_r4_replicated: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_we_o |-> mem_wdata_o == {(DW/8){mem_wdata_o[7:0]}});

  a_r2_tx_hold: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_count_mult: assert property (@(posedge clk) disable iff (rst)
    done_o |-> count_o[1:0] == 2'b00);

  a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(count_o));

  a_r7_loop_src: assert property (@(posedge clk) disable iff (rst)
    lb_valid_o |-> $past(loop_en_i) && $past(tx_valid_o && tx_ready_i));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_req_o && !tx_valid_o);
endmodule

bind byte_dma_packer dpk_checker #(.AW(AW), .DW(DW), .CW(CW)) u_dpk_checker (
  .clk(clk), .rst(rst), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdy_i(mem_rdy_i),
  .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
  .lb_valid_o(lb_valid_o), .loop_en_i(loop_en_i), .busy_o(busy_o),
  .done_o(done_o), .count_o(count_o)
);

// File: tb/tb_byte_dma_packer.sv
module tb_byte_dma_packer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, start_i, dir_i, loop_en_i;
  logic [31:0] base_i;
  logic        mem_req_o, mem_we_o, mem_rdy_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        tx_valid_o, tx_ready_i;
  logic [7:0]  tx_data_o;
  logic        rx_valid_i, rx_ready_o;
  logic [7:0]  rx_data_i;
  logic        lb_valid_o, busy_o, done_o;
  logic [7:0]  lb_data_o;
  logic [15:0] count_o;

  byte_dma_packer dut (.*);

  int checks = 0, errors = 0;
  int cyc = 0, n_reads = 0, n_writes = 0, done_seen = 0;
  logic [15:0] done_cnt;
  logic [7:0]  exp_tx[$], exp_lb[$], rxq[$];
  logic [63:0] exp_wr[$];
  bit rx_pop_pend = 0;

  function automatic logic [31:0] mw(input logic [31:0] a);
    logic [7:0] b;
    b = a[9:2];
    return {b ^ 8'h3C, b + 8'h07, b ^ 8'hA5, ~b};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Environment driver and scoreboard monitor, all on the falling edge
  initial begin
    mem_rdy_i = 0; tx_ready_i = 0; rx_valid_i = 0; rx_data_i = 0; mem_rdata_i = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rx_pop_pend && rxq.size() > 0) void'(rxq.pop_front());
      rx_valid_i  = (rxq.size() > 0);
      rx_data_i   = (rxq.size() > 0) ? rxq[0] : 8'h00;
      mem_rdy_i   = (cyc % 3) != 0;
      tx_ready_i  = (cyc % 4) != 1;
      mem_rdata_i = mw(mem_addr_o);
      #1;
      rx_pop_pend = rx_valid_i && rx_ready_o;
      if (mem_req_o && mem_rdy_i) begin
        if (mem_we_o) begin
          n_writes++;
          if (exp_wr.size() == 0) chk(0, "R4 unexpected write", {mem_addr_o, mem_wdata_o}, 0);
          else begin
            logic [63:0] e;
            e = exp_wr.pop_front();
            chk({mem_addr_o, mem_wdata_o} == e, "R4 write addr/data", {mem_addr_o, mem_wdata_o}, e);
          end
        end else n_reads++;
      end
      if (tx_valid_o && tx_ready_i) begin
        if (exp_tx.size() == 0) chk(0, "R2 unexpected tx byte", tx_data_o, 0);
        else begin
          logic [7:0] e;
          e = exp_tx.pop_front();
          chk(tx_data_o == e, "R2 tx byte lane 1", tx_data_o, e);
        end
      end
      if (lb_valid_o) begin
        if (exp_lb.size() == 0) chk(0, "R7 unexpected loopback", lb_data_o, 0);
        else begin
          logic [7:0] e;
          e = exp_lb.pop_front();
          chk(lb_data_o == e, "R7 loopback byte", lb_data_o, e);
        end
      end
      if (done_o) begin
        done_seen++;
        done_cnt = count_o;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic pulse_start(input logic dir, input logic [31:0] base);
    @(negedge clk);
    dir_i = dir; base_i = base; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int d0, input string req);
    int t;
    t = 0;
    while (done_seen == d0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(done_seen == d0 + 1, req, done_seen - d0, 1);
  endtask

  task automatic run_tx(input logic [31:0] base, input logic loop, input bit poke);
    logic [31:0] a;
    int n, r0, w0, d0;
    a = base & ~32'h3; n = 0;
    do begin
      exp_tx.push_back(mw(a)[15:8]);
      if (loop) exp_lb.push_back(mw(a)[15:8]);
      a = a + 4; n++;
    end while (a[11:2] != 0);
    r0 = n_reads; w0 = n_writes; d0 = done_seen;
    loop_en_i = loop;
    pulse_start(1'b0, base);
    if (poke) begin
      rxq.push_back(8'h77);
      repeat (3) @(negedge clk);
      pulse_start(1'b1, 32'h400);
    end
    wait_done(d0, "R6 one done per send");
    repeat (8) @(negedge clk);
    chk(done_seen == d0 + 1, "R6 single done pulse", done_seen - d0, 1);
    chk(done_cnt == 16'(n * 4), "R6 send byte count", done_cnt, n * 4);
    chk(count_o == 16'(n * 4), "R6 count holds", count_o, n * 4);
    chk(n_reads - r0 == n, "R3 word reads up to page end", n_reads - r0, n);
    chk(exp_tx.size() == 0, "R2 all bytes sent", exp_tx.size(), 0);
    chk(n_writes == w0, "R8 send issues no writes", n_writes - w0, 0);
    chk(exp_lb.size() == 0, "R7 loopback count", exp_lb.size(), 0);
    chk(!busy_o, "R3 idle after send", busy_o, 0);
    if (poke) begin
      chk(rxq.size() == 1, "R9 start during busy ignored", rxq.size(), 1);
      rxq.delete();
    end
    exp_tx.delete(); exp_lb.delete();
  endtask

  task automatic run_rx(input logic [31:0] base, input int nb, input logic [7:0] seed);
    logic [31:0] a;
    int k, d0;
    for (int i = 0; i < nb; i++) rxq.push_back(seed + 8'(i * 7));
    a = base & ~32'h3; k = 0;
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 7);
      exp_wr.push_back({a, {4{b}}});
      k++; a = a + 4;
      if (a[10:2] == 0) break;
    end
    d0 = done_seen;
    pulse_start(1'b1, base);
    wait_done(d0, "R6 one done per receive");
    repeat (4) @(negedge clk);
    chk(done_cnt == 16'(k * 4), "R5 receive byte count", done_cnt, k * 4);
    chk(exp_wr.size() == 0, "R4 all writes seen", exp_wr.size(), 0);
    chk(rxq.size() == nb - k, "R5 leftover queue bytes", rxq.size(), nb - k);
    chk(!busy_o, "R5 idle after receive", busy_o, 0);
    rxq.delete(); exp_wr.delete();
  endtask

  initial begin
    rst = 1; start_i = 0; dir_i = 0; base_i = 0; loop_en_i = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o && !tx_valid_o && !lb_valid_o, "R1 reset outputs idle",
        {busy_o, done_o, mem_req_o, tx_valid_o, lb_valid_o}, 0);
    chk(count_o == 0, "R1 reset count", count_o, 0);

    run_tx(32'h0000_1FF0, 1'b0, 1'b0);   // R2 R3: four words to page end, no loopback (R7)
    run_tx(32'h0000_2FFB, 1'b1, 1'b0);   // R10 unaligned base, R7 loopback on
    run_tx(32'h0000_3F80, 1'b1, 1'b1);   // R9 start while busy, 32 words
    run_rx(32'h0000_0100, 5, 8'h21);     // R4 R5: ends when queue empties
    run_rx(32'h0000_07F2, 10, 8'h90);    // R5 half-page end, R10 unaligned
    run_rx(32'h0000_0200, 0, 8'h00);     // R5 empty queue, zero count
    run_tx(32'h0000_0FFC, 1'b0, 1'b0);   // R3 single word at page end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule